// File: doc/BRIEF.md
# Serial flash command front-end (single-bit, 4-byte address)

This block is the device end of a single-lane serial flash link. The host selects it by pulling `cs_n` low. It then clocks in an 8-bit opcode followed by a 32-bit address on `si`, and the block answers on `so`. A small byte array stands in for the flash cells. The block handles plain and fast reads, page program and two sizes of sector erase, all with a 4-byte address. A status read reports whether an embedded program or erase is still running.

The block runs entirely in the `clk` domain. `sck`, `cs_n` and `si` are treated as synchronous inputs, and their edges are found by comparing each input with its registered copy. Program and erase commands take effect only when `cs_n` rises. Each one starts a busy window of `BUSY_CYCLES` clocks, shown on `wip`. During that window only the status opcode is served.

Top module: `sfl_cmd_front`

## Requirements
- R1: A command starts when `cs_n` falls and ends when `cs_n` rises. `sck` edges while `cs_n` is high have no effect. From the second clock with `cs_n` high, `so` is 0.
- R2: `si` is sampled on `sck` rising edges. The first 8 bits are the opcode, MSB first. The next 32 bits are the address, most significant byte first. Only the low log2(`MEM_BYTES`) address bits select a byte.
- R3: Opcode 0x13 (read) drives the byte at the address on `so`, MSB first, starting with the `sck` falling edge after the 40th rising edge. Each following falling edge moves to the next bit.
- R4: Opcode 0x0C (fast read) behaves like 0x13, but 8 dummy clocks are inserted, so data starts at the falling edge after the 48th rising edge.
- R5: Read data continues in ascending byte order for as long as `cs_n` stays low. It wraps from the last array byte back to byte 0.
- R6: Opcode 0x12 (program) takes data bytes after the address. Each byte is ANDed into the cell at page offset (address mod `PAGE_BYTES`) plus its index, and the offset wraps inside the same page.
- R7: Opcode 0x21 sets every byte of the `SMALL_SECT`-byte sector that holds the address to 0xFF. Opcode 0xDC does the same for the `LARGE_SECT`-byte sector.
- R8: A program or erase is carried out only if `cs_n` rises after at least 40 rising edges and after a multiple of 8 rising edges. Otherwise the array and `wip` stay unchanged.
- R9: Once a program or erase is carried out, `wip` is 1 for exactly `BUSY_CYCLES` clocks, starting on the clock after `cs_n` is seen high.
- R10: Opcode 0x05 (status) returns the byte {7'b0, wip} repeatedly, starting at the falling edge after the 8th rising edge. It is accepted while busy.
- R11: While `wip` is 1, any opcode other than 0x05 is ignored: `so` stays 0 and the array is unchanged.
- R12: After reset, `so` and `wip` are 0 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than `sck` |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| wip | output | 1 | High while a program or erase runs |

## Verification
An `sck` edge is seen on the clock where `sck` differs from its registered copy. A new `so` bit is therefore present one clock after the falling `sck` edge. The bench holds each `sck` phase for four clocks and reads `so` on the last clock before it raises `sck`, so every read bit has settled. `wip` rises one clock after `cs_n` goes high. The bench counts exactly how many falling clock edges `wip` stays high. Array effects of a program or erase appear as soon as the command closes. The bench reads them back through later read commands, which it issues only after `wip` has dropped.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
    typedef enum logic [2:0] {
        CMD_NONE, CMD_READ, CMD_FREAD, CMD_PROG, CMD_ERS_S, CMD_ERS_L, CMD_STAT
    } cmd_e;

    localparam logic [7:0] OPC_READ  = 8'h13;
    localparam logic [7:0] OPC_FREAD = 8'h0C;
    localparam logic [7:0] OPC_PROG  = 8'h12;
    localparam logic [7:0] OPC_ERS_S = 8'h21;
    localparam logic [7:0] OPC_ERS_L = 8'hDC;
    localparam logic [7:0] OPC_STAT  = 8'h05;

    function automatic cmd_e op_decode(input logic [7:0] op);
        case (op)
            OPC_READ:  return CMD_READ;
            OPC_FREAD: return CMD_FREAD;
            OPC_PROG:  return CMD_PROG;
            OPC_ERS_S: return CMD_ERS_S;
            OPC_ERS_L: return CMD_ERS_L;
            OPC_STAT:  return CMD_STAT;
            default:   return CMD_NONE;
        endcase
    endfunction
endpackage

// File: rtl/sfl_edge.sv
module sfl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_start,
    output logic sel_end
);
    typedef struct packed {
        logic sck;
        logic cs_n;
    } edge_t;

    edge_t q, d;

    always_comb begin
        d.sck  = sck;
        d.cs_n = cs_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{sck: 1'b0, cs_n: 1'b1};
        else        q <= d;
    end

    assign sck_rise  = sck  & ~q.sck & ~cs_n;
    assign sck_fall  = ~sck & q.sck  & ~cs_n;
    assign sel_start = ~cs_n & q.cs_n;
    assign sel_end   = cs_n  & ~q.cs_n;
endmodule

// File: rtl/sfl_busy.sv
module sfl_busy #(
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic wip
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(BUSY_CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign wip = (cnt_q != '0);

    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n) (cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R9
endmodule

// File: rtl/sfl_store.sv
module sfl_store #(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 256,
    parameter int SMALL_SECT = 128,
    parameter int LARGE_SECT = 512
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pg_clr,
    input  logic                          pg_we,
    input  logic [$clog2(PAGE_BYTES)-1:0] pg_idx,
    input  logic [7:0]                    pg_byte,
    input  logic                          do_prog,
    input  logic                          do_ers_s,
    input  logic                          do_ers_l,
    input  logic [$clog2(MEM_BYTES)-1:0]  op_addr,
    input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
    output logic [7:0]                    rd_byte
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int SSW = $clog2(SMALL_SECT);
    localparam int LSW = $clog2(LARGE_SECT);

    logic [7:0] mem_q  [MEM_BYTES];
    logic [7:0] mem_d  [MEM_BYTES];
    logic [7:0] pbuf_q [PAGE_BYTES];
    logic [7:0] pbuf_d [PAGE_BYTES];

    always_comb begin
        pbuf_d = pbuf_q;
        if (pg_clr) begin
            for (int j = 0; j < PAGE_BYTES; j++) pbuf_d[j] = 8'hFF;
        end else if (pg_we) begin
            pbuf_d[pg_idx] = pbuf_q[pg_idx] & pg_byte;
        end
    end

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < MEM_BYTES; i++) begin
            if (do_prog && ((AW'(i) >> PW) == (op_addr >> PW)))
                mem_d[AW'(i)] = mem_q[AW'(i)] & pbuf_q[PW'(i)];
            if (do_ers_s && ((AW'(i) >> SSW) == (op_addr >> SSW)))
                mem_d[AW'(i)] = 8'hFF;
            if (do_ers_l && ((AW'(i) >> LSW) == (op_addr >> LSW)))
                mem_d[AW'(i)] = 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++)  mem_q[i]  <= 8'hFF;
            for (int j = 0; j < PAGE_BYTES; j++) pbuf_q[j] <= 8'hFF;
        end else begin
            mem_q  <= mem_d;
            pbuf_q <= pbuf_d;
        end
    end

    assign rd_byte = mem_q[rd_addr];

    AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({do_prog, do_ers_s, do_ers_l})); // R7
    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n) do_prog |=> ((mem_q[$past(op_addr)] & ~$past(mem_q[op_addr])) == 8'h00)); // R6
    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) (do_ers_s || do_ers_l) |=> (mem_q[$past(op_addr)] == 8'hFF)); // R7
endmodule

// File: rtl/sfl_cmd_front.sv
module sfl_cmd_front
    import sfl_pkg::*;
#(
    parameter int MEM_BYTES   = 1024,
    parameter int PAGE_BYTES  = 256,
    parameter int SMALL_SECT  = 128,
    parameter int LARGE_SECT  = 512,
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic wip
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    typedef struct packed {
        cmd_e          cmd;
        logic [5:0]    cnt;     // rising edges, saturates at 48
        logic [2:0]    bpos;    // rising edges mod 8
        logic [6:0]    op_sr;
        logic [AW-1:0] addr;
        logic [PW-1:0] pg_off;
        logic [6:0]    din;
        logic [7:0]    dout;
        logic          so;
        logic [AW-1:0] rd_ptr;
    } st_t;

    st_t q, d;

    logic sck_rise, sck_fall, sel_start, sel_end;
    logic pg_clr, pg_we, do_prog, do_ers_s, do_ers_l, busy_go, aligned, data_on;
    logic [PW-1:0] pg_idx;
    logic [7:0] pg_byte, rd_byte, out_byte;
    cmd_e dec;

    sfl_edge u_edge (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sel_start(sel_start), .sel_end(sel_end)
    );

    sfl_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_go), .wip(wip)
    );

    sfl_store #(
        .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
        .SMALL_SECT(SMALL_SECT), .LARGE_SECT(LARGE_SECT)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .pg_clr(pg_clr), .pg_we(pg_we), .pg_idx(pg_idx), .pg_byte(pg_byte),
        .do_prog(do_prog), .do_ers_s(do_ers_s), .do_ers_l(do_ers_l),
        .op_addr(q.addr), .rd_addr(q.rd_ptr), .rd_byte(rd_byte)
    );

    assign aligned = (q.bpos == 3'd0) && (q.cnt >= 6'd40);
    assign dec     = op_decode({q.op_sr, si});
    assign data_on = ((q.cmd == CMD_READ)  && (q.cnt >= 6'd40)) ||
                     ((q.cmd == CMD_FREAD) && (q.cnt >= 6'd48)) ||
                     ((q.cmd == CMD_STAT)  && (q.cnt >= 6'd8));
    assign out_byte = (q.cmd == CMD_STAT) ? {7'b0, wip} : rd_byte;

    always_comb begin
        d        = q;
        pg_clr   = 1'b0;
        pg_we    = 1'b0;
        pg_idx   = q.pg_off;
        pg_byte  = {q.din, si};
        do_prog  = 1'b0;
        do_ers_s = 1'b0;
        do_ers_l = 1'b0;
        if (sel_start) begin
            d      = '0;
            pg_clr = 1'b1;
        end else if (sel_end) begin
            do_prog  = aligned && (q.cmd == CMD_PROG);
            do_ers_s = aligned && (q.cmd == CMD_ERS_S);
            do_ers_l = aligned && (q.cmd == CMD_ERS_L);
            d.cmd    = CMD_NONE;
            d.so     = 1'b0;
        end else begin
            if (sck_rise) begin
                d.cnt  = (q.cnt == 6'd48) ? q.cnt : q.cnt + 6'd1;
                d.bpos = q.bpos + 3'd1;
                if (q.cnt < 6'd8) begin
                    d.op_sr = {q.op_sr[5:0], si};
                    if (q.cnt == 6'd7)
                        d.cmd = (wip && dec != CMD_STAT) ? CMD_NONE : dec;
                end else if (q.cnt < 6'd40) begin
                    d.addr = {q.addr[AW-2:0], si};
                    if (q.cnt == 6'd39) begin
                        d.pg_off = PW'({q.addr[AW-2:0], si});
                        d.rd_ptr = {q.addr[AW-2:0], si};
                    end
                end else begin
                    d.din = {q.din[5:0], si};
                    if (q.cmd == CMD_PROG && q.bpos == 3'd7) begin
                        pg_we    = 1'b1;
                        d.pg_off = q.pg_off + PW'(1);
                    end
                end
            end
            if (sck_fall && data_on) begin
                if (q.bpos == 3'd0) begin
                    d.so   = out_byte[7];
                    d.dout = {out_byte[6:0], 1'b0};
                    if (q.cmd != CMD_STAT) d.rd_ptr = q.rd_ptr + AW'(1);
                end else begin
                    d.so   = q.dout[7];
                    d.dout = {q.dout[6:0], 1'b0};
                end
            end
        end
    end

    assign busy_go = do_prog | do_ers_s | do_ers_l;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign so = q.so;

    AST_SO_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) (cs_n && $past(cs_n)) |-> !so); // R1
    AST_WIP_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(wip) |-> $past(busy_go)); // R9
    AST_IDLE_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) ((q.cmd != CMD_NONE) && (q.cmd != CMD_STAT)) |-> !wip); // R11
endmodule

// File: tb/sfl_cmd_front_tb.sv
module sfl_cmd_front_tb;
    localparam int MEM  = 1024;
    localparam int PAGE = 256;
    localparam int SS   = 128;
    localparam int LS   = 512;
    localparam int BUSY = 1500;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, wip;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] ref_mem [MEM];

    always #10 clk = ~clk;

    sfl_cmd_front #(
        .MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .SMALL_SECT(SS),
        .LARGE_SECT(LS), .BUSY_CYCLES(BUSY)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .wip(wip)
    );

    function automatic int midx(input logic [31:0] a, input int k);
        return (int'(a % MEM) + k) % MEM;
    endfunction

    function automatic int pidx(input logic [31:0] a, input int k);
        return (int'(a % MEM) / PAGE) * PAGE + ((int'(a % PAGE) + k) % PAGE);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic o);
        si = b;
        tick(4);
        o = so;
        sck = 1'b1;
        tick(4);
        sck = 1'b0;
    endtask

    task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
        logic b;
        for (int k = 7; k >= 0; k--) begin
            bit_x(tx[k], b);
            rx[k] = b;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(2);
    endtask

    task automatic desel();
        tick(2);
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic header(input logic [7:0] op, input logic [31:0] a);
        logic [7:0] rx;
        byte_x(op, rx);
        for (int k = 3; k >= 0; k--) byte_x(a[k*8 +: 8], rx);
    endtask

    task automatic wait_idle();
        while (wip) tick(1);
    endtask

    // read n bytes, compare with model, or with 0 when the read must be ignored
    task automatic read_chk(input string req, input logic [7:0] op, input logic [31:0] a,
                            input int n, input bit ignored);
        logic [7:0] rx;
        sel();
        header(op, a);
        if (op == 8'h0C) byte_x(8'h00, rx);
        for (int k = 0; k < n; k++) begin
            byte_x(8'h00, rx);
            check(req, rx, ignored ? 8'h00 : ref_mem[midx(a, k)]);
        end
        desel();
        check("R1 so low after deselect", so, 1'b0);
    endtask

    task automatic prog(input logic [31:0] a, input int n, input logic [7:0] seed_byte, input bit model);
        logic [7:0] rx, v;
        sel();
        header(8'h12, a);
        for (int k = 0; k < n; k++) begin
            v = seed_byte ^ 8'(k * 37);
            byte_x(v, rx);
            if (model) ref_mem[pidx(a, k)] &= v;
        end
        desel();
    endtask

    task automatic erase(input logic [7:0] op, input logic [31:0] a, input bit model);
        int sz, base;
        sel();
        header(op, a);
        desel();
        sz = (op == 8'h21) ? SS : LS;
        base = (int'(a % MEM) / sz) * sz;
        if (model) for (int k = 0; k < sz; k++) ref_mem[base + k] = 8'hFF;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic b;
        int c;
        logic [31:0] a;
        void'($urandom(32'd7319));
        for (int k = 0; k < MEM; k++) ref_mem[k] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R12 so after reset", so, 1'b0);
        check("R12 wip after reset", wip, 1'b0);
        read_chk("R12 erased array", 8'h13, 32'h0000_0000, 3, 1'b0);

        // R1: clocks while deselected do nothing
        si = 1'b1;
        repeat (20) begin sck = 1'b1; tick(3); sck = 1'b0; tick(3); end
        check("R1 so while deselected", so, 1'b0);
        check("R1 wip unaffected", wip, 1'b0);

        // R6 + R9: program across page wrap, exact busy length
        sel();
        header(8'h12, 32'h0000_01FE);
        for (int k = 0; k < 4; k++) begin
            byte_x(8'h5A ^ 8'(k), rx);
            ref_mem[pidx(32'h1FE, k)] &= 8'h5A ^ 8'(k);
        end
        tick(2);
        cs_n = 1'b1;
        c = 0;
        tick(1);
        while (wip && c < 5000) begin c++; tick(1); end
        check("R9 wip length", c, BUSY);
        read_chk("R6 page wrap high end", 8'h13, 32'h0000_01FE, 2, 1'b0);
        read_chk("R6 page wrap low end", 8'h13, 32'h0000_0100, 2, 1'b0);
        check("R6 wrapped byte", ref_mem[256], 8'h58);

        // R6 AND semantics, R3, R4, R2
        prog(32'h0000_0010, 3, 8'hF0, 1'b1);
        wait_idle();
        prog(32'h0000_0010, 3, 8'h3C, 1'b1);
        wait_idle();
        read_chk("R3 plain read", 8'h13, 32'h0000_0010, 3, 1'b0);
        read_chk("R4 fast read", 8'h0C, 32'h0000_0010, 3, 1'b0);
        read_chk("R2 upper address ignored", 8'h13, 32'hA5C3_0010, 3, 1'b0);

        // R5 wrap at end of array
        prog(32'h0000_03FE, 2, 8'h11, 1'b1);
        wait_idle();
        prog(32'h0000_0000, 2, 8'h22, 1'b1);
        wait_idle();
        read_chk("R5 array wrap", 8'h13, 32'h0000_03FE, 4, 1'b0);

        // R10 / R11 while busy
        prog(32'h0000_0080, 1, 8'h0F, 1'b1);
        sel();
        byte_x(8'h05, rx);
        byte_x(8'h00, rx);
        check("R10 status busy", rx, 8'h01);
        byte_x(8'h00, rx);
        check("R10 status repeats", rx, 8'h01);
        desel();
        read_chk("R11 read ignored while busy", 8'h13, 32'h0000_0080, 2, 1'b1);
        prog(32'h0000_0081, 2, 8'h00, 1'b0);
        erase(8'hDC, 32'h0000_0000, 1'b0);
        wait_idle();
        sel();
        byte_x(8'h05, rx);
        byte_x(8'h00, rx);
        check("R10 status idle", rx, 8'h00);
        desel();
        read_chk("R11 array untouched", 8'h13, 32'h0000_0080, 2, 1'b0);

        // R8: off-boundary and short commands are dropped
        sel();
        header(8'h12, 32'h0000_0200);
        byte_x(8'h00, rx);
        for (int k = 0; k < 3; k++) bit_x(1'b0, b);
        desel();
        check("R8 no busy after partial byte", wip, 1'b0);
        sel();
        byte_x(8'h21, rx);
        byte_x(8'h00, rx);
        byte_x(8'h00, rx);
        desel();
        check("R8 no busy after short address", wip, 1'b0);
        read_chk("R8 array unchanged", 8'h13, 32'h0000_0200, 1, 1'b0);
        read_chk("R8 short erase no effect", 8'h13, 32'h0000_0010, 1, 1'b0);

        // R7 both erase sizes
        erase(8'h21, 32'h0000_0011, 1'b1);
        wait_idle();
        read_chk("R7 small sector erased", 8'h13, 32'h0000_0010, 3, 1'b0);
        read_chk("R7 outside small sector", 8'h13, 32'h0000_00FF, 3, 1'b0);
        erase(8'hDC, 32'h0000_0150, 1'b1);
        wait_idle();
        read_chk("R7 large sector erased", 8'h13, 32'h0000_01FE, 3, 1'b0);

        // constrained random mix
        for (int it = 0; it < 30; it++) begin
            a = $urandom;
            case ($urandom % 8)
                0, 1, 2: begin
                    prog(a, 1 + int'($urandom % 6), 8'($urandom), 1'b1);
                    wait_idle();
                end
                3: begin
                    erase(($urandom % 2) ? 8'h21 : 8'hDC, a, 1'b1);
                    wait_idle();
                end
                4, 5: read_chk("R3 random read", 8'h13, a, 4, 1'b0);
                default: read_chk("R4 random fast read", 8'h0C, a, 4, 1'b0);
            endcase
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule